// File: doc/BRIEF.md
# Configurable External Edge Interrupt Controller

A bank of independent interrupt-request lines, each watching one external input. A line can be set to trigger on rising edges, falling edges or both. Edges are caught by an asynchronous capture flop, so a pulse narrower than one bus clock period still registers. The capture is then synchronized into the bus clock domain, and the result sets a sticky pending bit.

Each pending bit is gated by its own interrupt mask to give a level interrupt output. A separate event mask turns the same detections into single-cycle event pulses, which are not latched. A small word-addressed register port sets the trigger selects and the masks. Software clears pending bits by writing ones, and can also raise lines by writing ones to a software-trigger register.

The low-numbered lines take their input through a pin selector, which lets a large set of GPIO pins share those lines. Each selectable line picks a port number and takes the pin with the same index as the line from that port. The remaining lines are driven by dedicated inputs.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, and `irq_o` and `evt_o` are all zero.
- R2: A line whose bit is set in the rising-select register (address 2) sets its pending bit on a 0-to-1 input transition. With that select clear and the falling select also clear, no transition sets it.
- R3: A line whose bit is set only in the falling-select register (address 3) sets its pending bit on a 1-to-0 transition and not on a 0-to-1 transition.
- R4: With both select bits set, either transition sets the pending bit.
- R5: An enabled edge of a pulse shorter than one clock period, falling entirely between two clock edges, still sets the pending bit.
- R6: Line j (j < 16) takes its input from pin index `sel*16 + j`, where `sel` is its 4-bit port field. The field sits at address 6 for lines 0-7 and address 7 for lines 8-15, at bits `[4*(j%8)+3 : 4*(j%8)]`. An index of 168 or more leaves the line with no source. Line k (k >= 16) is driven by `ext_i[k-16]`.
- R7: The pending register (address 5) reads the pending bits. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and pending bits are otherwise held.
- R8: An enabled edge detected in the same cycle as a write-1 clear of that line leaves the pending bit set.
- R9: `irq_o[k]` equals pending bit k ANDed with bit k of the interrupt-mask register (address 0).
- R10: With bit k set in the event-mask register (address 1), each detection on line k produces exactly one cycle of `evt_o[k]`, whatever the interrupt mask. With that bit clear, no event is produced.
- R11: Writing 1s to the software-trigger register (address 4) sets the matching pending bits as if an edge had occurred. The register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS (168) | Candidate GPIO pins for the selectable lines |
| ext_i | input | NUM_LINES-NUM_MUXED (8) | Dedicated inputs for the upper lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_o | output | NUM_LINES (24) | Masked pending interrupt levels |
| evt_o | output | NUM_LINES (24) | Single-cycle event pulses |

## Verification
The bench builds the block with its default parameters: 24 lines, 16 of them selectable, 168 pins in ports of 16. With this configuration it can sweep every line through all four trigger settings, covering both the pin-selected lines and the dedicated ones. For one line it walks every populated port, and it also selects the partly populated last port for a line whose pin does not exist there. Sub-nanosecond pulses inside a 4 ns period exercise asynchronous capture, and a precisely timed clear write lands in the same cycle as a detection.

// File: rtl/edge_irq_pkg.sv
`timescale 1ns/1ps
package edge_irq_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_IMASK  = 3'd0,
        A_EMASK  = 3'd1,
        A_RISE   = 3'd2,
        A_FALL   = 3'd3,
        A_SWTRIG = 3'd4,
        A_PEND   = 3'd5,
        A_PSEL0  = 3'd6,
        A_PSEL1  = 3'd7
    } reg_addr_e;

    localparam int unsigned PSEL_BASE = 6;
endpackage

// File: rtl/edge_irq_pinmux.sv
`timescale 1ns/1ps
module edge_irq_pinmux #(
    parameter int unsigned NUM_PINS  = 168,
    parameter int unsigned NUM_MUXED = 16,
    parameter int unsigned PORT_PINS = 16,
    parameter int unsigned SEL_W     = 4
) (
    input  logic [NUM_PINS-1:0]              pins_i,
    input  logic [NUM_MUXED-1:0][SEL_W-1:0]  psel_i,
    output logic [NUM_MUXED-1:0]             src_o
);
    localparam int unsigned SLOTS = 1 << SEL_W;

    for (genvar j = 0; j < NUM_MUXED; j++) begin : g_line
        logic [SLOTS-1:0] cand;
        for (genvar p = 0; p < SLOTS; p++) begin : g_port
            if (p * PORT_PINS + j < NUM_PINS) begin : g_pin
                assign cand[p] = pins_i[p * PORT_PINS + j];
            end else begin : g_none
                assign cand[p] = 1'b0;
            end
        end
        assign src_o[j] = cand[psel_i[j]];
    end
endmodule

// File: rtl/edge_irq_catch.sv
`timescale 1ns/1ps
module edge_irq_catch #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned CHAIN = SYNC_STAGES + 1;

    logic [1:0] hit_p;

    for (genvar pol = 0; pol < 2; pol++) begin : g_pol
        logic             catch_q;
        logic             clr;
        logic [CHAIN-1:0] sync_q;

        // the last chain stage acknowledges the capture and releases it
        assign clr = sync_q[CHAIN-1] | ~rst_n;

        if (pol == 0) begin : g_rise
            always_ff @(posedge sig_i or posedge clr) begin
                if (clr) catch_q <= 1'b0;
                else     catch_q <= 1'b1;
            end
        end else begin : g_fall
            always_ff @(negedge sig_i or posedge clr) begin
                if (clr) catch_q <= 1'b0;
                else     catch_q <= 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[CHAIN-2:0], catch_q};
        end

        assign hit_p[pol] = sync_q[CHAIN-2] & ~sync_q[CHAIN-1];
    end

    assign rise_o = hit_p[0];
    assign fall_o = hit_p[1];
endmodule

// File: rtl/edge_irq_regs.sv
`timescale 1ns/1ps
module edge_irq_regs
    import edge_irq_pkg::*;
#(
    parameter int unsigned NUM_LINES = 24,
    parameter int unsigned NUM_MUXED = 16,
    parameter int unsigned SEL_W     = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_wr,
    input  logic [ADDR_W-1:0]                reg_addr,
    input  logic [DATA_W-1:0]                reg_wdata,
    output logic [DATA_W-1:0]                reg_rdata,
    input  logic [NUM_LINES-1:0]             rise_p_i,
    input  logic [NUM_LINES-1:0]             fall_p_i,
    output logic [NUM_MUXED-1:0][SEL_W-1:0]  psel_o,
    output logic [NUM_LINES-1:0]             pend_o,
    output logic [NUM_LINES-1:0]             emask_o,
    output logic [NUM_LINES-1:0]             hit_o,
    output logic [NUM_LINES-1:0]             irq_o,
    output logic [NUM_LINES-1:0]             evt_o
);
    localparam int unsigned LPW = DATA_W / SEL_W;

    typedef struct packed {
        logic [NUM_LINES-1:0]            imask;
        logic [NUM_LINES-1:0]            emask;
        logic [NUM_LINES-1:0]            rise;
        logic [NUM_LINES-1:0]            fall;
        logic [NUM_LINES-1:0]            pend;
        logic [NUM_LINES-1:0]            evt;
        logic [NUM_MUXED-1:0][SEL_W-1:0] psel;
    } state_t;

    state_t               st_q, st_d;
    logic [NUM_LINES-1:0] hit, sw_set, clr;
    logic [NUM_LINES-1:0] wbits;

    assign wbits = reg_wdata[NUM_LINES-1:0];

    always_comb begin
        st_d   = st_q;
        sw_set = '0;
        clr    = '0;
        hit    = (rise_p_i & st_q.rise) | (fall_p_i & st_q.fall);
        if (reg_wr) begin
            case (reg_addr_e'(reg_addr))
                A_IMASK:  st_d.imask = wbits;
                A_EMASK:  st_d.emask = wbits;
                A_RISE:   st_d.rise  = wbits;
                A_FALL:   st_d.fall  = wbits;
                A_SWTRIG: sw_set     = wbits;
                A_PEND:   clr        = wbits;
                default: begin
                    for (int j = 0; j < int'(NUM_MUXED); j++) begin
                        if (32'(reg_addr) == PSEL_BASE + 32'(j) / LPW)
                            st_d.psel[j] = reg_wdata[(j % LPW) * SEL_W +: SEL_W];
                    end
                end
            endcase
        end
        // a detection wins over a clear arriving in the same cycle
        st_d.pend = (st_q.pend & ~clr) | hit | sw_set;
        st_d.evt  = (hit | sw_set) & st_q.emask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr_e'(reg_addr))
            A_IMASK:  reg_rdata = DATA_W'(st_q.imask);
            A_EMASK:  reg_rdata = DATA_W'(st_q.emask);
            A_RISE:   reg_rdata = DATA_W'(st_q.rise);
            A_FALL:   reg_rdata = DATA_W'(st_q.fall);
            A_SWTRIG: reg_rdata = '0;
            A_PEND:   reg_rdata = DATA_W'(st_q.pend);
            default: begin
                for (int j = 0; j < int'(NUM_MUXED); j++) begin
                    if (32'(reg_addr) == PSEL_BASE + 32'(j) / LPW)
                        reg_rdata[(j % LPW) * SEL_W +: SEL_W] = st_q.psel[j];
                end
            end
        endcase
    end

    assign psel_o  = st_q.psel;
    assign pend_o  = st_q.pend;
    assign emask_o = st_q.emask;
    assign hit_o   = hit;
    assign irq_o   = st_q.pend & st_q.imask;
    assign evt_o   = st_q.evt;
endmodule

// File: rtl/edge_irq_ctrl.sv
`timescale 1ns/1ps
module edge_irq_ctrl
    import edge_irq_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 24,
    parameter int unsigned NUM_MUXED   = 16,
    parameter int unsigned NUM_PINS    = 168,
    parameter int unsigned PORT_PINS   = 16,
    parameter int unsigned SEL_W       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PINS-1:0]            pins_i,
    input  logic [NUM_LINES-NUM_MUXED-1:0] ext_i,
    input  logic                           reg_wr,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic [DATA_W-1:0]              reg_wdata,
    output logic [DATA_W-1:0]              reg_rdata,
    output logic [NUM_LINES-1:0]           irq_o,
    output logic [NUM_LINES-1:0]           evt_o
);
    logic [NUM_MUXED-1:0][SEL_W-1:0] psel_w;
    logic [NUM_MUXED-1:0]            mux_src;
    logic [NUM_LINES-1:0]            line_in;
    logic [NUM_LINES-1:0]            rise_p, fall_p;
    logic [NUM_LINES-1:0]            pend_w, emask_w, hit_w;

    edge_irq_pinmux #(
        .NUM_PINS (NUM_PINS),
        .NUM_MUXED(NUM_MUXED),
        .PORT_PINS(PORT_PINS),
        .SEL_W    (SEL_W)
    ) u_mux (
        .pins_i(pins_i),
        .psel_i(psel_w),
        .src_o (mux_src)
    );

    assign line_in = {ext_i, mux_src};

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_catch
        edge_irq_catch #(.SYNC_STAGES(SYNC_STAGES)) u_catch (
            .clk   (clk),
            .rst_n (rst_n),
            .sig_i (line_in[k]),
            .rise_o(rise_p[k]),
            .fall_o(fall_p[k])
        );
    end

    edge_irq_regs #(
        .NUM_LINES(NUM_LINES),
        .NUM_MUXED(NUM_MUXED),
        .SEL_W    (SEL_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .rise_p_i (rise_p),
        .fall_p_i (fall_p),
        .psel_o   (psel_w),
        .pend_o   (pend_w),
        .emask_o  (emask_w),
        .hit_o    (hit_w),
        .irq_o    (irq_o),
        .evt_o    (evt_o)
    );
endmodule

// File: rtl/edge_irq_chk.sv
`timescale 1ns/1ps
module edge_irq_chk
    import edge_irq_pkg::*;
#(
    parameter int unsigned NUM_LINES = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic [NUM_LINES-1:0] pend,
    input logic [NUM_LINES-1:0] hit,
    input logic [NUM_LINES-1:0] emask,
    input logic [NUM_LINES-1:0] irq,
    input logic [NUM_LINES-1:0] evt
);
    logic                 pend_wr;
    logic [NUM_LINES-1:0] wbits;
    assign pend_wr = reg_wr && (reg_addr == A_PEND);
    assign wbits   = reg_wdata[NUM_LINES-1:0];

    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr |=> ((pend & $past(wbits & ~hit)) == '0));

    // R7
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr |=> ((pend & $past(pend & ~wbits)) == $past(pend & ~wbits)));

    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_wr |=> ((pend & $past(pend)) == $past(pend)));

    // R8
    clear_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr |=> ((pend & $past(hit)) == $past(hit)));

    // R9
    irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~pend) == '0));

    // R10
    evt_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |-> ((evt & ~$past(emask)) == '0));
endmodule

bind edge_irq_ctrl edge_irq_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .pend     (pend_w),
    .hit      (hit_w),
    .emask    (emask_w),
    .irq      (irq_o),
    .evt      (evt_o)
);

// File: tb/tb_edge_irq_ctrl.sv
`timescale 1ns/1ps
module tb_edge_irq_ctrl;
    localparam int NL = 24, NM = 16, NP = 168, PP = 16;
    localparam int A_IM = 0, A_EM = 1, A_RI = 2, A_FA = 3, A_SW = 4, A_PE = 5, A_PS0 = 6, A_PS1 = 7;
    localparam logic [31:0] ALL = (32'd1 << NL) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic [NL-NM-1:0] ext = '0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NL-1:0] irq, evt;

    int total = 0, bad = 0;
    int cur_port [NM];
    int evt_cnt = 0;
    logic [NL-1:0] evt_other = '0;
    int evt_line = 0;

    always #2 clk = ~clk;

    edge_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .ext_i(ext),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq), .evt_o(evt)
    );

    always @(negedge clk) begin
        if (evt[evt_line]) evt_cnt++;
        evt_other |= evt & ~(NL'(1) << evt_line);
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 3'(a);
        #0.1;
        d = reg_rdata;
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_line(int ln, logic v);
        if (ln < NM) pins[cur_port[ln] * PP + ln] = v;
        else         ext[ln - NM] = v;
    endtask

    task automatic short_pulse(int ln);
        @(negedge clk);
        #0.5 set_line(ln, 1'b1);
        #0.6 set_line(ln, 1'b0);
    endtask

    logic [31:0] rv;

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int j = 0; j < NM; j++) cur_port[j] = 0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(a, rv);
            chk("R1 reg", rv, 32'd0);
        end
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 evt", 32'(evt), 32'd0);

        // R2 R3 R4: every line through all four trigger settings
        for (int ln = 0; ln < NL; ln++) begin
            for (int m = 0; m < 4; m++) begin
                string tag;
                logic [31:0] bit_ln;
                tag = (m == 2) ? "R3" : (m == 3) ? "R4" : "R2";
                bit_ln = 32'd1 << ln;
                wr(A_RI, m[0] ? bit_ln : 32'd0);
                wr(A_FA, m[1] ? bit_ln : 32'd0);
                wr(A_PE, ALL);
                set_line(ln, 1'b1);
                wait_clk(8);
                rd(A_PE, rv);
                chk({tag, " rising"}, rv, m[0] ? bit_ln : 32'd0);
                wr(A_PE, ALL);
                set_line(ln, 1'b0);
                wait_clk(8);
                rd(A_PE, rv);
                chk({tag, " falling"}, rv, m[1] ? bit_ln : 32'd0);
            end
        end

        // R5: pulses much shorter than the clock period
        wr(A_RI, ALL);
        wr(A_FA, 32'd0);
        for (int ln = 0; ln < NL; ln += 5) begin
            wr(A_PE, ALL);
            short_pulse(ln);
            wait_clk(8);
            rd(A_PE, rv);
            chk("R5 short pulse", rv, 32'd1 << ln);
        end

        // R6: line 3 across every populated port
        for (int p = 0; p < 11; p++) begin
            int other;
            wr(A_PS0, 32'(p) << 12);
            cur_port[3] = p;
            rd(A_PS0, rv);
            chk("R6 readback", rv, 32'(p) << 12);
            wr(A_PE, ALL);
            pins[p * PP + 3] = 1'b1; wait_clk(2); pins[p * PP + 3] = 1'b0;
            wait_clk(8);
            rd(A_PE, rv);
            chk("R6 selected pin", rv, 32'd1 << 3);
            other = ((p + 1) % 11) * PP + 3;
            wr(A_PE, ALL);
            pins[other] = 1'b1; wait_clk(2); pins[other] = 1'b0;
            wait_clk(8);
            rd(A_PE, rv);
            chk("R6 unselected pin", rv, 32'd0);
        end
        wr(A_PS0, 32'd0);
        cur_port[3] = 0;
        // R6: line 9 from port 4 (pin 73), field in the second select word
        wr(A_PS1, 32'd4 << 4);
        cur_port[9] = 4;
        wr(A_PE, ALL);
        pins[73] = 1'b1; wait_clk(2); pins[73] = 1'b0;
        wait_clk(8);
        rd(A_PE, rv);
        chk("R6 line9 port4", rv, 32'd1 << 9);
        // R6: line 12 on port 10 has no pin (index 172)
        wr(A_PS1, 32'd10 << 16);
        wr(A_PE, ALL);
        pins = '1; wait_clk(2); pins = '0;
        wait_clk(8);
        rd(A_PE, rv);
        chk("R6 missing pin", rv & (32'd1 << 12), 32'd0);
        wr(A_PS1, 32'd0);
        cur_port[9] = 0;
        wait_clk(8);

        // R11 and R7
        wr(A_PE, ALL);
        wr(A_SW, ALL);
        rd(A_PE, rv);
        chk("R11 sw trigger", rv, ALL);
        rd(A_SW, rv);
        chk("R11 reads zero", rv, 32'd0);
        wr(A_PE, 32'd0);
        rd(A_PE, rv);
        chk("R7 write zero", rv, ALL);
        wr(A_PE, 32'h00F0F0);
        rd(A_PE, rv);
        chk("R7 partial clear", rv, ALL & ~32'h00F0F0);

        // R9
        wr(A_SW, ALL);
        wr(A_IM, 32'h5A5A5A);
        wait_clk(1);
        chk("R9 masked irq", 32'(irq), 32'h5A5A5A);
        wr(A_PE, 32'h0000FF);
        wait_clk(1);
        chk("R9 after clear", 32'(irq), 32'h5A5A00);
        wr(A_IM, 32'd0);
        wait_clk(1);
        chk("R9 mask off", 32'(irq), 32'd0);

        // R8: clear write lands in the detection cycle of line 5
        wr(A_PE, ALL);
        wr(A_SW, 32'd1 << 5);
        @(negedge clk);
        #0.5 pins[5] = 1'b1;
        #0.6 pins[5] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(A_PE); reg_wdata = 32'd1 << 5;
        @(negedge clk);
        reg_wr = 1'b0;
        wait_clk(8);
        rd(A_PE, rv);
        chk("R8 race keeps bit", rv, 32'd1 << 5);

        // R10: event pulses
        wr(A_PE, ALL);
        wr(A_EM, 32'd1 << 7);
        wait_clk(2);
        evt_line = 7; evt_cnt = 0; evt_other = '0;
        short_pulse(7);
        wait_clk(10);
        chk("R10 one event", 32'(evt_cnt), 32'd1);
        chk("R10 no other event", 32'(evt_other), 32'd0);
        chk("R10 irq masked", 32'(irq), 32'd0);
        rd(A_PE, rv);
        chk("R10 pending kept", rv, 32'd1 << 7);
        evt_cnt = 0;
        wr(A_SW, 32'd1 << 7);
        wait_clk(3);
        chk("R10 sw event", 32'(evt_cnt), 32'd1);
        evt_line = 8; evt_cnt = 0; evt_other = '0;
        short_pulse(8);
        wait_clk(10);
        chk("R10 masked event", 32'(evt_cnt), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule